// File: doc/BRIEF.md
# Flash and Torch Mode Controller with Flash Watchdog

This block decides, every clock, whether a high-power LED is dark, in continuous torch mode or in a timed flash. It also decides whether a low-current indicator LED is lit and passes a current code to the analog regulators. It is driven either by two hardwired control bits or by register fields that a serial host programs. A select input chooses between the two. In register mode a flash is requested by a strobe pin or by a software strobe bit, and the block times every flash against a watchdog that counts an external tick.

Two watchdog styles are offered in register mode. In the timed style, a strobe starts a flash that lasts exactly the programmed period. In the held style, the flash follows the strobe pin, and a flash that outlasts the period is cut off and latches a timeout fault. A latched fault darkens every LED and blocks new flashes until the host clears it. The software strobe is acknowledged in the cycle it is consumed, so the register bit can clear itself.

Top module: `flash_wdt_ctrl`

## Requirements
- R1: With `hw_mode`=1, `ctrl` 2'b00 turns everything off, 2'b01 lights only the indicator (code `HW_IND_CODE`), 2'b10 gives torch (code `HW_TORCH_CODE`) and 2'b11 gives a flash (code `HW_FLASH_CODE`, `hp_flash`=1).
- R2: With `hw_mode`=1 the flash watchdog always uses the timer code 0 period. If `ctrl` stays 2'b11 beyond it, the flash ends, `fault` latches and `timeout_evt` pulses for one cycle together with the rise of `fault`. Leaving 2'b11 earlier ends the flash without a fault.
- R3: With `hw_mode`=0, an `hp_code` of 0 keeps the LED off, codes 1..`TORCH_LAST` give torch (`hp_on`=1, `hp_flash`=0) whatever the strobe does, and higher codes keep the LED off until a strobe starts a flash. `hp_sel` shows `hp_code` while lit and 0 when off.
- R4: With `hw_mode`=1 the `strobe_pin` and `sw_strobe` inputs have no effect on any output.
- R5: With `timed_mode`=1, a rising edge of `strobe_pin` starts a flash on the next clock. The flash lasts exactly the period and then ends without a fault, even if the pin stays high.
- R6: With `timed_mode`=0, a high `strobe_pin` starts a flash that lasts while the pin stays high. Releasing the pin ends it without a fault. Reaching the period ends it and latches the timeout fault.
- R7: The period is the larger of `BASE_COUNT - code*STEP_COUNT` and `MIN_COUNT`, counted in cycles with `tick`=1. It is latched when the flash starts.
- R8: With `hw_mode`=0, an `ind_code` of 0 keeps the indicator off and any other code lights it, with `ind_sel`=`ind_code`.
- R9: While `fault` is 1, `hp_on`, `ind_on`, `hp_sel` and `ind_sel` are 0 and no flash can start. `fault_clr` clears the fault, and a timeout in the same cycle takes priority over the clear.
- R10: With `hw_mode`=0, a set `sw_strobe` starts a flash of the full period that ends without a fault. `sw_ack` is 1 in the cycle the strobe is consumed: when it starts a flash, or when it is dropped because `fault` is set.
- R11: A flash in progress ends on the next clock when the flash condition goes away: `hp_code` leaves the flash range, `hw_mode` changes, or `ctrl` leaves 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Watchdog time base enable |
| hw_mode | input | 1 | 1 selects the hardwired control bits, 0 the register fields |
| ctrl | input | 2 | Hardwired mode select |
| strobe_pin | input | 1 | Flash strobe pin (register mode) |
| sw_strobe | input | 1 | Software strobe register bit |
| hp_code | input | HP_W | High-power LED code register |
| ind_code | input | IND_W | Indicator code register |
| tmr_code | input | TMR_W | Watchdog period code |
| timed_mode | input | 1 | 1 timed flash, 0 held flash |
| fault_clr | input | 1 | Clears the latched fault |
| hp_on | output | 1 | High-power LED enable |
| hp_flash | output | 1 | Flash in progress |
| hp_sel | output | HP_W | Current code for the high-power regulator |
| ind_on | output | 1 | Indicator enable |
| ind_sel | output | IND_W | Current code for the indicator |
| sw_ack | output | 1 | Software strobe consumed |
| fault | output | 1 | Latched timeout fault |
| timeout_evt | output | 1 | One-cycle timeout pulse |

## Verification
A wrong flash state shows at `hp_flash`, `hp_on` and `hp_sel` in the same cycle. A counter or period latched wrongly shows as a flash that ends one or more ticks early or late, or as a fault that is missing or unexpected at the expiry cycle. A stuck or early fault shows at once as dark LED outputs, and a lost edge or level record shows as a flash that starts, or fails to start, on the clock after the strobe. Every output is compared each cycle against a behavioural model. With shortened periods, every expiry falls within a few dozen cycles of the strobe that started it.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

   typedef enum logic [1:0] {
      HWSEL_OFF   = 2'b00,
      HWSEL_IND   = 2'b01,
      HWSEL_TORCH = 2'b10,
      HWSEL_FLASH = 2'b11
   } hwsel_e;

   typedef struct packed {
      logic flash_ok;   // flash range / flash state selected
      logic torch_on;   // continuous torch selected
      logic hold_lvl;   // level that keeps a held flash alive
      logic ind_on;     // indicator selected
   } mode_req_t;

endpackage

// File: rtl/fc_decode.sv
module fc_decode
   import flash_ctrl_pkg::*;
#(
   parameter int HP_W       = 5,
   parameter int IND_W      = 3,
   parameter int TORCH_LAST = 11
) (
   input  logic             hw_mode,
   input  logic [1:0]       ctrl,
   input  logic [HP_W-1:0]  hp_code,
   input  logic [IND_W-1:0] ind_code,
   input  logic             strobe_pin,
   output mode_req_t        req
);
   localparam logic [HP_W-1:0] LAST = HP_W'(TORCH_LAST);

   hwsel_e sel;
   assign sel = hwsel_e'(ctrl);

   always_comb begin
      if (hw_mode) begin
         req.flash_ok = (sel == HWSEL_FLASH);
         req.torch_on = (sel == HWSEL_TORCH);
         req.hold_lvl = (sel == HWSEL_FLASH);
         req.ind_on   = (sel == HWSEL_IND);
      end else begin
         req.flash_ok = (hp_code > LAST);
         req.torch_on = (hp_code != '0) && (hp_code <= LAST);
         req.hold_lvl = strobe_pin;
         req.ind_on   = (ind_code != '0);
      end
   end

   // R3: torch and flash ranges never overlap
   always_comb a_r3_ranges_disjoint: assert (!(req.flash_ok && req.torch_on));
endmodule

// File: rtl/fc_watchdog.sv
module fc_watchdog #(
   parameter int TMR_W      = 4,
   parameter int BASE_COUNT = 983040,
   parameter int STEP_COUNT = 65536,
   parameter int MIN_COUNT  = 65536
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             run,
   input  logic [TMR_W-1:0] code,
   output logic             expire
);
   localparam int CNT_W = $clog2(BASE_COUNT + 1);
   localparam int PW    = CNT_W + TMR_W + 1;

   logic [CNT_W-1:0] cnt, term_q, term_d;

   generate
      if (STEP_COUNT == 0) begin : g_fixed
         assign term_d = CNT_W'(BASE_COUNT);
      end else begin : g_linear
         logic [PW-1:0] dec;
         assign dec = PW'(code) * PW'(STEP_COUNT);
         always_comb begin
            if (dec + PW'(MIN_COUNT) > PW'(BASE_COUNT))
               term_d = CNT_W'(MIN_COUNT);
            else
               term_d = CNT_W'(PW'(BASE_COUNT) - dec);
         end
      end
   endgenerate

   assign expire = run && tick && ((cnt + CNT_W'(1)) >= term_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         term_q <= CNT_W'(BASE_COUNT);
      end else if (load) begin
         cnt    <= '0;
         term_q <= term_d;
      end else if (run && tick && !expire) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R7: a running count never reaches the latched period
   a_r7_cnt_below_term: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < term_q));
   // R7: the latched period respects the floor
   a_r7_term_floor: assert property (@(posedge clk) disable iff (!rst_n)
      term_q >= CNT_W'(MIN_COUNT));
endmodule

// File: rtl/fc_seq.sv
module fc_seq
   import flash_ctrl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hw_mode,
   input  logic      timed_mode,
   input  logic      strobe_pin,
   input  logic      sw_strobe,
   input  logic      fault_clr,
   input  mode_req_t req,
   input  logic      expire,
   output logic      flashing,
   output logic      start,
   output logic      sw_ack,
   output logic      fault,
   output logic      timeout_evt
);
   logic strb_q, held_q, mode_q;
   logic pin_go, sw_go, hw_go, abort, timeout;

   assign pin_go  = !hw_mode && (timed_mode ? (strobe_pin && !strb_q) : strobe_pin);
   assign sw_go   = !hw_mode && sw_strobe;
   assign hw_go   = hw_mode && req.flash_ok;
   assign start   = !flashing && !fault && req.flash_ok && (hw_go || pin_go || sw_go);
   assign sw_ack  = sw_go && !flashing && (fault || start);
   assign abort   = flashing && (!req.flash_ok || (held_q && !req.hold_lvl) || (hw_mode != mode_q));
   assign timeout = flashing && !abort && expire && held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q      <= 1'b0;
         flashing    <= 1'b0;
         held_q      <= 1'b0;
         mode_q      <= 1'b0;
         fault       <= 1'b0;
         timeout_evt <= 1'b0;
      end else begin
         strb_q      <= strobe_pin;
         timeout_evt <= timeout;
         if (start) begin
            flashing <= 1'b1;
            held_q   <= hw_mode || (!timed_mode && strobe_pin);
            mode_q   <= hw_mode;
         end else if (abort || expire) begin
            flashing <= 1'b0;
         end
         if (timeout)        fault <= 1'b1;
         else if (fault_clr) fault <= 1'b0;
      end
   end

   // R6: a fault only rises at the end of a held flash
   a_r6_fault_from_held: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> ($past(flashing) && $past(held_q)));
   // R2: the timeout pulse accompanies the latched fault
   a_r2_evt_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_evt |-> fault);
   // R9: no flash starts or runs while faulted
   a_r9_no_flash_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !flashing);
   // R10: the software strobe is only consumed from idle
   a_r10_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ack |-> !flashing);
endmodule

// File: rtl/flash_wdt_ctrl.sv
module flash_wdt_ctrl
   import flash_ctrl_pkg::*;
#(
   parameter int HP_W          = 5,
   parameter int IND_W         = 3,
   parameter int TMR_W         = 4,
   parameter int TORCH_LAST    = 11,
   parameter int BASE_COUNT    = 983040,
   parameter int STEP_COUNT    = 65536,
   parameter int MIN_COUNT     = 65536,
   parameter int HW_TORCH_CODE = 6,
   parameter int HW_FLASH_CODE = 31,
   parameter int HW_IND_CODE   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hw_mode,
   input  logic [1:0]       ctrl,
   input  logic             strobe_pin,
   input  logic             sw_strobe,
   input  logic [HP_W-1:0]  hp_code,
   input  logic [IND_W-1:0] ind_code,
   input  logic [TMR_W-1:0] tmr_code,
   input  logic             timed_mode,
   input  logic             fault_clr,
   output logic             hp_on,
   output logic             hp_flash,
   output logic [HP_W-1:0]  hp_sel,
   output logic             ind_on,
   output logic [IND_W-1:0] ind_sel,
   output logic             sw_ack,
   output logic             fault,
   output logic             timeout_evt
);
   generate
      if (TORCH_LAST < 1 || TORCH_LAST >= (1 << HP_W) - 1) begin : g_bad_range
         $error("TORCH_LAST must leave both a torch and a flash range");
      end
      if (MIN_COUNT < 1 || MIN_COUNT > BASE_COUNT) begin : g_bad_min
         $error("MIN_COUNT must lie in 1..BASE_COUNT");
      end
      if (HW_FLASH_CODE >= (1 << HP_W) || HW_TORCH_CODE >= (1 << HP_W)
          || HW_IND_CODE >= (1 << IND_W)) begin : g_bad_codes
         $error("hardwired codes do not fit their fields");
      end
   endgenerate

   mode_req_t        req;
   logic             flashing, start, expire;
   logic [TMR_W-1:0] wd_code;

   fc_decode #(.HP_W(HP_W), .IND_W(IND_W), .TORCH_LAST(TORCH_LAST)) u_dec (
      .hw_mode(hw_mode), .ctrl(ctrl), .hp_code(hp_code), .ind_code(ind_code),
      .strobe_pin(strobe_pin), .req(req));

   assign wd_code = hw_mode ? '0 : tmr_code;

   fc_watchdog #(.TMR_W(TMR_W), .BASE_COUNT(BASE_COUNT), .STEP_COUNT(STEP_COUNT),
                 .MIN_COUNT(MIN_COUNT)) u_wd (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(start), .run(flashing),
      .code(wd_code), .expire(expire));

   fc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .timed_mode(timed_mode),
      .strobe_pin(strobe_pin), .sw_strobe(sw_strobe), .fault_clr(fault_clr),
      .req(req), .expire(expire), .flashing(flashing), .start(start),
      .sw_ack(sw_ack), .fault(fault), .timeout_evt(timeout_evt));

   assign hp_flash = flashing;
   assign hp_on    = !fault && (flashing || req.torch_on);
   assign ind_on   = !fault && req.ind_on;

   always_comb begin
      if (!hp_on)       hp_sel = '0;
      else if (hw_mode) hp_sel = flashing ? HP_W'(HW_FLASH_CODE) : HP_W'(HW_TORCH_CODE);
      else              hp_sel = hp_code;
      if (!ind_on)      ind_sel = '0;
      else if (hw_mode) ind_sel = IND_W'(HW_IND_CODE);
      else              ind_sel = ind_code;
   end

   // R9: a latched fault keeps every LED dark
   a_r9_dark_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!hp_on && !ind_on && hp_sel == '0 && ind_sel == '0));
   // R2: a hardwired flash that times out does not come back while faulted
   a_r2_hw_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_evt && hw_mode) |-> !hp_flash);
endmodule

// File: tb/sim_flash_wdt_ctrl.sv
module sim_flash_wdt_ctrl;
   localparam int BASE = 40, STEP = 4, MINC = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hw_mode = 0, strobe_pin = 0, timed_mode = 0, fault_clr = 0;
   logic sw_set = 0, sw_reg = 0, tick;
   logic [1:0] ctrl = 0;
   logic [4:0] hp_code = 0;
   logic [2:0] ind_code = 0;
   logic [3:0] tmr_code = 0;
   logic hp_on, hp_flash, ind_on, sw_ack, fault, timeout_evt;
   logic [4:0] hp_sel;
   logic [2:0] ind_sel;
   int tphase = 0, n_cmp = 0, n_bad = 0;
   bit armed = 0, done = 0;
   string cur_req = "R3";

   always #4 clk = ~clk;

   flash_wdt_ctrl #(.BASE_COUNT(BASE), .STEP_COUNT(STEP), .MIN_COUNT(MINC)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hw_mode(hw_mode), .ctrl(ctrl),
      .strobe_pin(strobe_pin), .sw_strobe(sw_reg), .hp_code(hp_code),
      .ind_code(ind_code), .tmr_code(tmr_code), .timed_mode(timed_mode),
      .fault_clr(fault_clr), .hp_on(hp_on), .hp_flash(hp_flash), .hp_sel(hp_sel),
      .ind_on(ind_on), .ind_sel(ind_sel), .sw_ack(sw_ack), .fault(fault),
      .timeout_evt(timeout_evt));

   assign tick = (tphase != 0);
   always @(posedge clk) begin
      tphase <= (tphase + 1) % 3;
      sw_reg <= sw_set ? 1'b1 : (sw_ack ? 1'b0 : sw_reg);
      armed  <= 1'b1;
   end

   // behavioural reference state
   bit m_fl = 0, m_hd = 0, m_md = 0, m_ft = 0, m_evt = 0, m_sq = 0;
   int m_cnt = 0, m_term = BASE;

   function automatic int period(int code);
      int t = BASE - code * STEP;
      return (t < MINC) ? MINC : t;
   endfunction

   function automatic bit fok_now();
      return hw_mode ? (ctrl == 2'b11) : (hp_code > 11);
   endfunction

   function automatic bit start_now();
      bit go;
      if (hw_mode) go = 1'b1;
      else go = (timed_mode ? (strobe_pin && !m_sq) : strobe_pin) || sw_reg;
      return !m_fl && !m_ft && fok_now() && go;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fl = 0; m_hd = 0; m_md = 0; m_ft = 0; m_evt = 0; m_sq = 0; m_cnt = 0; m_term = BASE;
      end else begin
         bit st, tmo, holdl, ab, ex;
         st = start_now();
         tmo = 0;
         holdl = hw_mode ? (ctrl == 2'b11) : strobe_pin;
         if (m_fl) begin
            ab = !fok_now() || (m_hd && !holdl) || (hw_mode != m_md);
            ex = tick && (m_cnt + 1 >= m_term);
            tmo = !ab && ex && m_hd;
            if (ab || ex) m_fl = 0;
            else if (tick) m_cnt++;
         end
         m_evt = tmo;
         if (tmo) m_ft = 1;
         else if (fault_clr) m_ft = 0;
         if (st) begin
            m_fl = 1; m_cnt = 0;
            m_hd = hw_mode || (!timed_mode && strobe_pin);
            m_md = hw_mode;
            m_term = period(hw_mode ? 0 : int'(tmr_code));
         end
         m_sq = strobe_pin;
      end
   end

   task automatic cmp(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (armed && !done) begin
      bit torch, e_on, e_ion, e_ack;
      int e_sel, e_isel;
      torch = hw_mode ? (ctrl == 2'b10) : (hp_code >= 1 && hp_code <= 11);
      e_on  = !m_ft && (m_fl || torch);
      e_sel = !e_on ? 0 : (hw_mode ? (m_fl ? 31 : 6) : int'(hp_code));
      e_ion = !m_ft && (hw_mode ? (ctrl == 2'b01) : (ind_code != 0));
      e_isel = !e_ion ? 0 : (hw_mode ? 4 : int'(ind_code));
      e_ack = !hw_mode && sw_reg && !m_fl && (m_ft || start_now());
      cmp("hp_on", hp_on, e_on);
      cmp("hp_flash", hp_flash, m_fl);
      cmp("hp_sel", hp_sel, e_sel);
      cmp("ind_on", ind_on, e_ion);
      cmp("ind_sel", ind_sel, e_isel);
      cmp("sw_ack", sw_ack, e_ack);
      cmp("fault", fault, m_ft);
      cmp("timeout_evt", timeout_evt, m_evt);
   end

   task automatic go(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic clear_fault();
      fault_clr = 1; go(1); fault_clr = 0;
   endtask

   task automatic sw_pulse();
      sw_set = 1; go(1); sw_set = 0;
   endtask

   initial begin
      go(3);
      cur_req = "R3";            // reset state: everything dark
      rst_n = 1; go(3);

      cur_req = "R1";
      hw_mode = 1;
      ctrl = 2'b00; go(5);
      ctrl = 2'b01; go(5);
      ctrl = 2'b10; go(5);
      ctrl = 2'b11; go(20);      // short flash, ends normally
      ctrl = 2'b00; go(4);

      cur_req = "R4";
      ctrl = 2'b10;
      for (int i = 0; i < 6; i++) begin strobe_pin = ~strobe_pin; go(2); end
      sw_pulse(); go(4);
      strobe_pin = 0;

      cur_req = "R2";
      ctrl = 2'b11; go(140);     // exceeds the code 0 period
      cur_req = "R9";
      ctrl = 2'b10; go(4);
      ctrl = 2'b01; go(4);
      ctrl = 2'b00; clear_fault(); go(4);

      cur_req = "R3";
      hw_mode = 0; ctrl = 0;
      foreach (hp_code[i]) ;
      hp_code = 0;  strobe_pin = 1; go(4); strobe_pin = 0; go(2);
      hp_code = 5;  strobe_pin = 1; go(4); strobe_pin = 0; go(2);
      hp_code = 11; strobe_pin = 1; go(4); strobe_pin = 0; go(2);
      hp_code = 12; go(6);

      cur_req = "R8";
      ind_code = 0; go(3);
      ind_code = 3; go(3);
      ind_code = 7; go(3);
      ind_code = 0; go(2);

      cur_req = "R5";
      timed_mode = 1; hp_code = 20; tmr_code = 7;
      strobe_pin = 1; go(1); strobe_pin = 0; go(40);
      cur_req = "R7";
      tmr_code = 9;  strobe_pin = 1; go(20); strobe_pin = 0; go(4);
      tmr_code = 15; strobe_pin = 1; go(2); strobe_pin = 0; go(12);
      tmr_code = 2;  strobe_pin = 1; go(1); tmr_code = 15; strobe_pin = 0; go(110);

      cur_req = "R6";
      timed_mode = 0; tmr_code = 8;
      strobe_pin = 1; go(8); strobe_pin = 0; go(4);
      strobe_pin = 1; go(40);
      cur_req = "R9";
      strobe_pin = 0; go(2); strobe_pin = 1; go(3); strobe_pin = 0; go(2);
      cur_req = "R10";
      sw_pulse(); go(4);         // dropped while faulted
      cur_req = "R9";
      clear_fault(); go(4);

      cur_req = "R10";
      timed_mode = 0; tmr_code = 6;
      sw_pulse(); go(50);
      timed_mode = 1; sw_pulse(); go(50);

      cur_req = "R11";
      tmr_code = 0; strobe_pin = 1; go(1); strobe_pin = 0; go(10);
      hp_code = 5; go(4);
      hp_code = 25; strobe_pin = 1; go(1); strobe_pin = 0; go(6);
      hp_code = 0; go(4);
      hp_code = 25; timed_mode = 0; strobe_pin = 1; go(6);
      hw_mode = 1; go(4);
      hw_mode = 0; strobe_pin = 0; go(4);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule